// File: doc/BRIEF.md
# Local bus slave cycle front-end

This block sits between a 32-bit synchronous local bus and the register window of a network controller. It holds the word address, the I/O qualifier and the byte enables in a transparent latch. The latch follows the bus while the address strobe is low and freezes when the strobe returns high. On the next clock edge it decides whether the access is aimed at its window. If it is, it opens an internal cycle, samples the transfer direction on the first edge of that cycle and performs one register access.

Each register has its own set of allowed access widths. The data register takes byte, half-word and word accesses. Every other register takes only byte and half-word accesses. An access of a width that its target does not allow is still acknowledged, but it writes nothing and reads zero. The cycle ends with an active-low ready. The ready pin is driven low for one clock, then driven high for one clock, then released. Its output enable is a separate port, so the pad can behave like an open drain. The block sees reset through an inverter, so its reset input is active low.

Top module: `lbus_slave_fe`

## Requirements
- R1: While `ads_ni` is low, changes on `addr_i` reach the decoder. The value on `addr_i` when `ads_ni` rises is held for the rest of the access, and later changes on `addr_i` have no effect on it.
- R2: A cycle opens only when two conditions are met. First, the latched address bits [ADDR_W-1:REG_AW] equal `BASE`. Second, the latched `aen_i` is low. If either condition fails, there is no cycle, no ready and no write.
- R3: `be_ni` is latched the same way as the address. Bit n low enables lane n, which is bits 8n+7:8n. A write changes only the enabled lanes.
- R4: `wr_i` is sampled on the first rising clock edge on which `cyc_o` is high. 1 means write and 0 means read. Its value at any other time has no effect.
- R5: `cyc_o` rises on the clock edge after `ads_ni` is seen low with a hit. It stays high until ready has been returned. One strobe yields exactly one access, even if `ads_ni` stays low.
- R6: The data register (index `DATA_IDX`) accepts three widths: byte (one lane), half-word (lanes 1:0 or 3:2) and word (all four lanes).
- R7: All other registers accept only byte and half-word accesses. A word access, a scattered-lane access or an access with no lanes is acknowledged, writes nothing and reads zero.
- R8: `srdy_no` and `lrdy_o` are low, with `lrdy_oe_o` high, for exactly one clock. The next clock drives `lrdy_o` high with `lrdy_oe_o` high. After that, `lrdy_oe_o` is low.
- R9: While `rst_ni` is low, the following hold: `cyc_o=0`, `srdy_no=1`, `lrdy_oe_o=0`, `rdata_o=0`, and every register is zero.
- R10: A read returns the enabled lanes of the register on `rdata_o`, with zero in the other lanes. The value is valid while `srdy_no` is low and held until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local bus clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low (inverted bus reset) |
| ads_ni | input | 1 | Address strobe, active low |
| addr_i | input | ADDR_W | Word address bits 15:2 |
| aen_i | input | 1 | Address-enable qualifier, access allowed when low |
| be_ni | input | 4 | Byte enables, active low |
| wr_i | input | 1 | Direction, 1 write, 0 read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| cyc_o | output | 1 | Internal cycle active |
| srdy_no | output | 1 | Internal slave ready, active low |
| lrdy_o | output | 1 | Local ready pin value |
| lrdy_oe_o | output | 1 | Local ready pin output enable |

## Verification
The bench builds the block with ADDR_W=14, REG_AW=3, BASE=11'h0C0 and DATA_IDX=2. That gives eight registers: the data register at index 2 and seven width-restricted registers beside it. With these values, a single run can check byte, half-word and word lanes on the data register, and the width refusals on its neighbours. A base other than 11'h0C0 gives the miss case. The indices 4, 5 and 6 let one strobe show that an address change while the strobe is low is taken and that a change after its rise is dropped.

// File: rtl/lbus_fe_pkg.sv
package lbus_fe_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned DATA_W = LANES * 8;

  typedef enum logic [1:0] {ACC_BYTE, ACC_HALF, ACC_WORD, ACC_BAD} acc_width_e;
  typedef enum logic [1:0] {ST_IDLE, ST_CYC, ST_ACK, ST_REL} cyc_state_e;

  function automatic acc_width_e classify(input logic [LANES-1:0] lanes);
    acc_width_e w;
    w = ACC_BAD;
    if ($countones(lanes) == 1) w = ACC_BYTE;
    else if (lanes == {LANES{1'b1}}) w = ACC_WORD;
    else begin
      for (int p = 0; p < LANES / 2; p++) begin
        if (lanes == (LANES'(2'b11) << (2 * p))) w = ACC_HALF;
      end
    end
    return w;
  endfunction
endpackage

// File: rtl/lbus_addr_latch.sv
module lbus_addr_latch #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned LANES  = 4
) (
  input  logic              ads_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aen_i,
  input  logic [LANES-1:0]  be_ni,
  output logic [ADDR_W-1:0] addr_o,
  output logic              aen_o,
  output logic [LANES-1:0]  lanes_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              aen_q;
  logic [LANES-1:0]  be_q;

  // transparent while strobe low, frozen from its rising edge
  always_latch begin
    if (!ads_ni) begin
      addr_q <= addr_i;
      aen_q  <= aen_i;
      be_q   <= be_ni;
    end
  end

  assign addr_o  = addr_q;
  assign aen_o   = aen_q;
  assign lanes_o = ~be_q;
endmodule

// File: rtl/lbus_cycle_fsm.sv
module lbus_cycle_fsm
  import lbus_fe_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ads_ni,
  input  logic hit_i,
  output logic exec_o,
  output logic cyc_o,
  output logic srdy_no,
  output logic lrdy_o,
  output logic lrdy_oe_o
);
  cyc_state_e state_q;
  logic       armed_q;
  logic       start;

  assign start = (state_q == ST_IDLE) && armed_q && !ads_ni && hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) state_q <= ST_CYC;
        ST_CYC:  state_q <= ST_ACK;
        ST_ACK:  state_q <= ST_REL;
        ST_REL:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
      // one access per strobe: rearm only once strobe seen high
      if (ads_ni)     armed_q <= 1'b1;
      else if (start) armed_q <= 1'b0;
    end
  end

  assign exec_o    = (state_q == ST_CYC);
  assign cyc_o     = (state_q == ST_CYC) || (state_q == ST_ACK);
  assign srdy_no   = (state_q != ST_ACK);
  assign lrdy_o    = (state_q != ST_ACK);
  assign lrdy_oe_o = (state_q == ST_ACK) || (state_q == ST_REL);
endmodule

// File: rtl/lbus_reg_bank.sv
module lbus_reg_bank
  import lbus_fe_pkg::*;
#(
  parameter int unsigned REG_AW   = 3,
  parameter int unsigned DATA_IDX = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] idx_i,
  input  logic [LANES-1:0]  lanes_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned       NREGS    = 1 << REG_AW;
  localparam logic [REG_AW-1:0] DATA_SEL = REG_AW'(DATA_IDX);

  acc_width_e        width;
  logic              allowed;
  logic              wr_go;
  logic              rd_go;
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] reg_val [NREGS];
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    width = classify(lanes_i);
    if (idx_i == DATA_SEL) allowed = (width != ACC_BAD);
    else                   allowed = (width == ACC_BYTE) || (width == ACC_HALF);
  end

  assign wr_go = exec_i && wr_i && allowed;
  assign rd_go = exec_i && !wr_i;

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign lane_mask[l*8 +: 8] = {8{lanes_i[l]}};
  end

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (wr_go && (idx_i == REG_AW'(r))) begin
        for (int l = 0; l < LANES; l++) begin
          if (lanes_i[l]) q[l*8 +: 8] <= wdata_i[l*8 +: 8];
        end
      end
    end
    assign reg_val[r] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_go) rdata_q <= allowed ? (reg_val[idx_i] & lane_mask) : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/lbus_slave_fe.sv
module lbus_slave_fe
  import lbus_fe_pkg::*;
#(
  parameter int unsigned              ADDR_W   = 14,
  parameter int unsigned              REG_AW   = 3,
  parameter logic [ADDR_W-REG_AW-1:0] BASE     = 'h0C0,
  parameter int unsigned              DATA_IDX = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ads_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aen_i,
  input  logic [LANES-1:0]  be_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cyc_o,
  output logic              srdy_no,
  output logic              lrdy_o,
  output logic              lrdy_oe_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              aen_q;
  logic [LANES-1:0]  lanes_q;
  logic              hit;
  logic              exec;

  lbus_addr_latch #(.ADDR_W(ADDR_W), .LANES(LANES)) i_latch (
    .ads_ni (ads_ni),
    .addr_i (addr_i),
    .aen_i  (aen_i),
    .be_ni  (be_ni),
    .addr_o (addr_q),
    .aen_o  (aen_q),
    .lanes_o(lanes_q)
  );

  assign hit = (addr_q[ADDR_W-1:REG_AW] == BASE) && !aen_q;

  lbus_cycle_fsm i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ads_ni   (ads_ni),
    .hit_i    (hit),
    .exec_o   (exec),
    .cyc_o    (cyc_o),
    .srdy_no  (srdy_no),
    .lrdy_o   (lrdy_o),
    .lrdy_oe_o(lrdy_oe_o)
  );

  lbus_reg_bank #(.REG_AW(REG_AW), .DATA_IDX(DATA_IDX)) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .exec_i (exec),
    .wr_i   (wr_i),
    .idx_i  (addr_q[REG_AW-1:0]),
    .lanes_i(lanes_q),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/lbus_slave_fe_chk.sv
module lbus_slave_fe_chk #(
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ads_ni,
  input logic              cyc_o,
  input logic              srdy_no,
  input logic              lrdy_o,
  input logic              lrdy_oe_o,
  input logic [ADDR_W-1:0] addr_q
);
  assert_rdy_in_cyc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srdy_no |-> cyc_o);

  assert_cyc_needs_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cyc_o) |-> $past(!ads_ni));

  assert_rdy_one_clk_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srdy_no |=> srdy_no);

  assert_rdy_pin_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srdy_no |-> (lrdy_oe_o && !lrdy_o));

  assert_rdy_drive_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srdy_no |=> (lrdy_oe_o && lrdy_o));

  assert_rdy_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrdy_oe_o && lrdy_o) |=> !lrdy_oe_o);

  assert_addr_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_ni && $past(ads_ni)) |-> $stable(addr_q));
endmodule

bind lbus_slave_fe lbus_slave_fe_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ads_ni   (ads_ni),
  .cyc_o    (cyc_o),
  .srdy_no  (srdy_no),
  .lrdy_o   (lrdy_o),
  .lrdy_oe_o(lrdy_oe_o),
  .addr_q   (addr_q)
);

// File: tb/test_lbus_slave_fe.sv
`timescale 1ns/1ps
module test_lbus_slave_fe;
  localparam logic [10:0] BASE = 11'h0C0;
  localparam int NVEC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ads_n = 1'b1;
  logic [13:0] addr = '0;
  logic        aen = 1'b0;
  logic [3:0]  be_n = 4'hF;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cyc, srdy_n, lrdy, lrdy_oe;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lbus_slave_fe #(.ADDR_W(14), .REG_AW(3), .BASE(BASE), .DATA_IDX(2)) i_lbus_slave_fe (
    .clk_i(clk), .rst_ni(rst_n), .ads_ni(ads_n), .addr_i(addr), .aen_i(aen),
    .be_ni(be_n), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .cyc_o(cyc),
    .srdy_no(srdy_n), .lrdy_o(lrdy), .lrdy_oe_o(lrdy_oe)
  );

  // {wr, idx, lanes(active high), wdata, expected read}
  localparam logic [71:0] VEC [NVEC] = '{
    {1'b1, 3'd2, 4'b1111, 32'h11223344, 32'h0},
    {1'b0, 3'd2, 4'b1111, 32'h0,        32'h11223344},
    {1'b1, 3'd2, 4'b0001, 32'hAAAAAAAA, 32'h0},
    {1'b0, 3'd2, 4'b1111, 32'h0,        32'h112233AA},
    {1'b1, 3'd2, 4'b1100, 32'hBBBBCCCC, 32'h0},
    {1'b0, 3'd2, 4'b1111, 32'h0,        32'hBBBB33AA},
    {1'b0, 3'd2, 4'b0011, 32'h0,        32'h000033AA},
    {1'b1, 3'd0, 4'b1111, 32'hFFFFFFFF, 32'h0},
    {1'b0, 3'd0, 4'b0011, 32'h0,        32'h00000000},
    {1'b1, 3'd0, 4'b0011, 32'h12345678, 32'h0},
    {1'b0, 3'd0, 4'b1111, 32'h0,        32'h00000000},
    {1'b0, 3'd0, 4'b0011, 32'h0,        32'h00005678},
    {1'b1, 3'd1, 4'b0100, 32'h00990000, 32'h0},
    {1'b0, 3'd1, 4'b0100, 32'h0,        32'h00990000},
    {1'b1, 3'd2, 4'b0101, 32'h77777777, 32'h0},
    {1'b0, 3'd2, 4'b1111, 32'h0,        32'hBBBB33AA}
  };

  function automatic logic [13:0] ra(input int idx);
    return {BASE, 3'(idx)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [13:0] a0, input logic [13:0] a1, input logic [13:0] a2,
                        input logic [3:0] lanes, input logic wr0, input logic wr1,
                        input logic [31:0] wd, input logic aen_v, input bit exp_cyc,
                        input string tag, output logic [31:0] rd);
    @(negedge clk);
    ads_n = 1'b0; addr = a0; be_n = ~lanes; wr = wr0; wdata = wd; aen = aen_v;
    #1 addr = a1;
    @(posedge clk); @(negedge clk);
    chk({tag, " R5 cyc open"}, 32'(cyc), 32'(exp_cyc));
    ads_n = 1'b1;
    #1 addr = a2; wr = wr1;
    @(posedge clk); @(negedge clk);
    rd = rdata;
    if (exp_cyc) begin
      chk({tag, " R8 ready low"}, {29'd0, srdy_n, lrdy, lrdy_oe}, 32'b001);
      chk({tag, " R5 cyc held"}, 32'(cyc), 32'd1);
    end else begin
      chk({tag, " R2 no ready"}, {30'd0, srdy_n, lrdy_oe}, 32'b10);
    end
    @(posedge clk); @(negedge clk);
    if (exp_cyc) begin
      chk({tag, " R8 drive high"}, {29'd0, srdy_n, lrdy, lrdy_oe}, 32'b111);
      chk({tag, " R5 cyc closed"}, 32'(cyc), 32'd0);
    end
    @(posedge clk); @(negedge clk);
    chk({tag, " R8 released"}, 32'(lrdy_oe), 32'd0);
    aen = 1'b0;
  endtask

  task automatic simple(input int idx, input logic [3:0] lanes, input logic w,
                        input logic [31:0] wd, input string tag, output logic [31:0] rd);
    access(ra(idx), ra(idx), ra(idx), lanes, w, w, wd, 1'b0, 1'b1, tag, rd);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL R5 watchdog expired act=%0d exp=0", 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [71:0] v;
    logic [31:0] rd;
    int pulses;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset outputs", {28'd0, cyc, srdy_n, lrdy_oe, 1'b0}, 32'b0100);
    chk("R9 reset rdata", rdata, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // vector table: R3 R6 R7 R10
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      simple(int'(v[70:68]), v[67:64], v[71], v[63:32], $sformatf("vec%0d R3 R6 R7", i), rd);
      if (!v[71]) chk($sformatf("vec%0d R10 read", i), rd, v[31:0]);
    end

    // R1: change while low taken, change after rise ignored
    access(ra(4), ra(5), ra(6), 4'b0011, 1'b1, 1'b1, 32'hCAFE0001, 1'b0, 1'b1, "latch", rd);
    simple(5, 4'b0011, 1'b0, 32'h0, "R1 rd5", rd);
    chk("R1 low-time address taken", rd, 32'h00000001);
    simple(4, 4'b0011, 1'b0, 32'h0, "R1 rd4", rd);
    chk("R1 early address dropped", rd, 32'h0);
    simple(6, 4'b0011, 1'b0, 32'h0, "R1 rd6", rd);
    chk("R1 post-rise address ignored", rd, 32'h0);

    // R2: qualifier high, and base miss
    access(ra(7), ra(7), ra(7), 4'b0011, 1'b1, 1'b1, 32'h0000BEEF, 1'b1, 1'b0, "R2 aen", rd);
    access({11'h0C1, 3'd7}, {11'h0C1, 3'd7}, {11'h0C1, 3'd7}, 4'b0011, 1'b1, 1'b1,
           32'h0000DEAD, 1'b0, 1'b0, "R2 miss", rd);
    simple(7, 4'b0011, 1'b0, 32'h0, "R2 rd7", rd);
    chk("R2 no write on qualifier/miss", rd, 32'h0);

    // R4: direction sampled on first cycle edge
    access(ra(3), ra(3), ra(3), 4'b0001, 1'b0, 1'b1, 32'h0000005A, 1'b0, 1'b1, "R4 late wr", rd);
    access(ra(3), ra(3), ra(3), 4'b0001, 1'b1, 1'b0, 32'h000000FF, 1'b0, 1'b1, "R4 late rd", rd);
    chk("R4 late read returns data", rd, 32'h0000005A);
    simple(3, 4'b0001, 1'b0, 32'h0, "R4 rd3", rd);
    chk("R4 late write took effect, late read wrote nothing", rd, 32'h0000005A);

    // R5: strobe held low gives one access
    pulses = 0;
    @(negedge clk);
    ads_n = 1'b0; addr = ra(2); be_n = 4'h0; wr = 1'b0; aen = 1'b0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (!srdy_n) pulses++;
    end
    chk("R5 one access per strobe", 32'(pulses), 32'd1);
    ads_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: reset clears registers
    rst_n = 1'b0;
    #1;
    chk("R9 async reset", {29'd0, cyc, srdy_n, lrdy_oe}, 32'b010);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    simple(2, 4'b1111, 1'b0, 32'h0, "R9 rd2", rd);
    chk("R9 registers cleared", rd, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule